// File: doc/BRIEF.md
# Timer clock source selector

This block is the front end of a general-purpose timer. It decides what advances a programmable prescaler, and through it an up-counter with a reload limit. Everything runs in the bus clock domain. In the default modes the prescaler steps on every enabled bus clock cycle. In event mode it steps once for each rising edge of one trigger input picked by a select field. Each trigger line is synchronized and edge-detected into a one-cycle pulse, so no derived clock exists anywhere.

The counter counts from zero up to the reload value and then wraps to zero, raising a one-cycle update pulse as it wraps. A software update strobe also raises the update pulse. It clears the prescaler and the counter and loads a new prescaler divisor. A restart input clears the prescaler and the counter without an update. In event mode with trigger select zero, the software strobe is the trigger source: it updates the counter and never increments it.

Top module: `tmr_clksel`

## Requirements
- R1: After reset, `cnt` is 0 and `upd` is 0, and the active divisor is 1 (prescaler value 0).
- R2: For every `mode_sel` value 0 to 6, each bus clock cycle with `cnt_en` high is one prescaler tick.
- R3: The prescaler divides ticks by the active prescaler value plus one. The counter steps once every (value+1) ticks.
- R4: The counter counts 0, 1, ..., `reload` and then returns to 0. The cycle in which it wraps raises `upd` for exactly one cycle.
- R5: With `mode_sel` = 7 and `trig_sel` = k in 1..NTRIG, one tick occurs per rising edge of `trig_in[k-1]`. Other trigger lines have no effect. The count changes three bus clocks after the input rises.
- R6: With `mode_sel` = 7 and `trig_sel` = 0, or `trig_sel` greater than NTRIG, trigger activity never changes the counter.
- R7: A cycle with `sw_upd` high (and `restart` low) clears the prescaler and the counter on the next edge and raises `upd` for one cycle. This applies in every mode, including event mode with `trig_sel` = 0.
- R8: `restart` clears the prescaler and the counter on the next edge and does not raise `upd`. It wins over `sw_upd` and over a tick in the same cycle.
- R9: A new `psc_val` takes effect only at an update event (software or wrap). Until then the previously loaded divisor stays active.
- R10: With `cnt_en` low, and no software update or restart, `cnt` holds and `upd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Slave mode select; 7 = external event counting |
| trig_sel | input | SEL_W | Trigger select; 0 = software strobe, k = trig_in[k-1] |
| trig_in | input | NTRIG | Asynchronous trigger lines |
| sw_upd | input | 1 | Software update strobe, one cycle per request |
| psc_val | input | PSC_W | Prescaler value; divisor is value+1 |
| reload | input | CNT_W | Counter wrap limit |
| cnt_en | input | 1 | Counter enable |
| restart | input | 1 | Clears prescaler and counter |
| cnt | output | CNT_W | Counter value |
| upd | output | 1 | One-cycle update event pulse |

## Verification
The assertions assume that `mode_sel` and `trig_sel` stay fixed while an edge pulse is in flight. They also assume that `reload` is never lowered below the current count, so the counter only ever steps by one or clears. The stimulus changes configuration only while `cnt_en` is low, and then applies a software update before it counts. Trigger pulses stay high and low for three bus clocks each, so every edge passes the synchronizer cleanly and the expected count is just the number of selected edges divided by the divisor.

// File: rtl/tmr_clksel.sv
module tmr_clksel #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int NTRIG = 4,
  localparam int SEL_W = $clog2(NTRIG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             sw_upd,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             cnt_en,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);

  localparam logic [2:0] MODE_EVENT = 3'd7;

  logic [NTRIG-1:0] sync1, sync2, sync3;
  logic [NTRIG-1:0] edges;
  logic             sel_edge;
  logic             tick;
  logic             psc_wrap;
  logic             cnt_wrap;
  logic [PSC_W-1:0] psc_cnt, psc_act;
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= trig_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign edges = sync2 & ~sync3;

  always_comb begin
    sel_edge = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (int'(trig_sel) == i + 1) sel_edge = edges[i];
  end

  assign tick     = cnt_en & ((mode_sel == MODE_EVENT) ? sel_edge : 1'b1);
  assign psc_wrap = tick & (psc_cnt == psc_act);
  assign cnt_wrap = psc_wrap & (cnt_q == reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      psc_act <= '0;
      cnt_q   <= '0;
      upd_q   <= 1'b0;
    end else if (restart) begin
      psc_cnt <= '0;
      cnt_q   <= '0;
      upd_q   <= 1'b0;
    end else if (sw_upd) begin
      psc_cnt <= '0;
      cnt_q   <= '0;
      psc_act <= psc_val;
      upd_q   <= 1'b1;
    end else if (psc_wrap) begin
      psc_cnt <= '0;
      if (cnt_wrap) begin
        cnt_q   <= '0;
        psc_act <= psc_val;
        upd_q   <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        upd_q   <= 1'b0;
      end
    end else begin
      if (tick) psc_cnt <= psc_cnt + 1'b1;
      upd_q <= 1'b0;
    end
  end

  assign cnt = cnt_q;
  assign upd = upd_q;

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && !upd);

  a_r7_sw_update: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd && !restart) |=> upd && (cnt == '0));

  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sw_upd && !restart) |=> $stable(cnt) && !upd);

  a_r4_step_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_upd && !restart && (cnt < reload)) |=>
      ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)) && !upd);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_edge && $stable(trig_sel)) |=> !sel_edge || (trig_sel != $past(trig_sel)));

  a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == MODE_EVENT) && (trig_sel == '0) && !sw_upd && !restart) |=> $stable(cnt));

endmodule

// File: tb/tmr_clksel_tb.sv
module tmr_clksel_tb_top;
  localparam int CNT_W = 8;
  localparam int PSC_W = 4;
  localparam int NTRIG = 4;
  localparam int SEL_W = $clog2(NTRIG + 1);

  logic clk = 0, rst_n = 0;
  logic [2:0] mode_sel = 0;
  logic [SEL_W-1:0] trig_sel = 0;
  logic [NTRIG-1:0] trig_in = 0;
  logic sw_upd = 0, cnt_en = 0, restart = 0;
  logic [PSC_W-1:0] psc_val = 0;
  logic [CNT_W-1:0] reload = 0;
  logic [CNT_W-1:0] cnt;
  logic upd;

  int n_chk = 0, n_bad = 0, n_upd = 0;

  always #10 clk = ~clk;

  tmr_clksel #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NTRIG(NTRIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_sel(trig_sel),
    .trig_in(trig_in), .sw_upd(sw_upd), .psc_val(psc_val), .reload(reload),
    .cnt_en(cnt_en), .restart(restart), .cnt(cnt), .upd(upd));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_sw();
    sw_upd = 1;
    @(negedge clk);
    sw_upd = 0;
  endtask

  task automatic run_ticks(input int n);
    n_upd = 0;
    cnt_en = 1;
    repeat (n) begin
      @(negedge clk);
      if (upd) n_upd++;
    end
    cnt_en = 0;
  endtask

  task automatic pulse(input int idx, input int k);
    for (int j = 0; j < k; j++) begin
      trig_in = NTRIG'(1 << idx);
      repeat (3) @(negedge clk);
      trig_in = ~NTRIG'(1 << idx);
      repeat (3) @(negedge clk);
    end
    trig_in = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset cnt", int'(cnt), 0);
    chk("R1 reset upd", int'(upd), 0);
    rst_n = 1;
    @(negedge clk);
    reload = 8'd200;
    run_ticks(3);
    chk("R1 reset divisor 1", int'(cnt), 3);

    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        psc_val = PSC_W'(p); reload = CNT_W'(r);
        do_sw();
        chk("R7 sw update pulse", int'(upd), 1);
        run_ticks(23);
        chk("R3 R4 count value", int'(cnt), ((23 / (p + 1)) % (r + 1)));
        chk("R4 wrap updates", n_upd, ((23 / (p + 1)) / (r + 1)));
      end

    psc_val = 0; reload = 8'd100;
    for (int m = 0; m < 7; m++) begin
      mode_sel = 3'(m);
      do_sw();
      run_ticks(5);
      chk("R2 internal clock mode", int'(cnt), 5);
    end

    mode_sel = 3'd7;
    for (int s = 1; s <= NTRIG; s++)
      for (int p = 0; p < 2; p++) begin
        trig_sel = SEL_W'(s); psc_val = PSC_W'(p);
        do_sw();
        cnt_en = 1;
        pulse(s - 1, 5);
        cnt_en = 0;
        chk("R5 event count", int'(cnt), 5 / (p + 1));
      end

    trig_sel = 0; psc_val = 0;
    do_sw();
    cnt_en = 1;
    pulse(0, 4);
    chk("R6 sel zero no count", int'(cnt), 0);
    sw_upd = 1;
    @(negedge clk);
    sw_upd = 0;
    chk("R7 sel zero sw update", int'(upd), 1);
    chk("R7 sel zero cnt", int'(cnt), 0);
    trig_sel = SEL_W'(NTRIG + 1);
    pulse(1, 3);
    chk("R6 out of range sel", int'(cnt), 0);
    cnt_en = 0;

    mode_sel = 0; trig_sel = 0; psc_val = 3; reload = 8'd50;
    do_sw();
    run_ticks(10);
    run_ticks(2);
    restart = 1; cnt_en = 1;
    @(negedge clk);
    restart = 0; cnt_en = 0;
    chk("R8 restart cnt", int'(cnt), 0);
    chk("R8 restart no upd", int'(upd), 0);
    run_ticks(3);
    chk("R8 prescaler cleared", int'(cnt), 0);
    run_ticks(1);
    chk("R8 prescaler cleared step", int'(cnt), 1);
    restart = 1; sw_upd = 1;
    @(negedge clk);
    restart = 0; sw_upd = 0;
    chk("R8 restart beats sw", int'(upd), 0);

    psc_val = 0; reload = 8'd100;
    do_sw();
    psc_val = 3;
    run_ticks(4);
    chk("R9 old divisor kept", int'(cnt), 4);
    do_sw();
    run_ticks(8);
    chk("R9 new divisor at update", int'(cnt), 2);

    repeat (5) @(negedge clk);
    chk("R10 hold cnt", int'(cnt), 2);
    chk("R10 no upd", int'(upd), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule